// File: doc/BRIEF.md
# Power-Down and Wake-Up Controller

This block governs a processor core's low-power halt state. A halt strobe issued while the core runs stops the system clock and sets the power-down flag. From then on the block watches four wake sources: an external reset, a watchdog overflow, a newly raised interrupt request, and a falling edge on any wake-enabled input pin. Interrupt requests that were already pending when the halt was taken are masked and cannot wake the device.

Once a wake source is accepted, the clock is restarted and a fixed settling window runs. Its default length is 1024 system clock periods. Busy stays high for the whole window. In the last cycle of the window the block issues a one-cycle resume command. The command tells the core whether to continue at the next instruction, enter the interrupt response, perform a warm reset, or perform a full initialisation.

The block also keeps two reset-cause flags, power-down and time-out. Software reads them after wake-up to find out why the core restarted.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After the synchronous active-low power-up reset, `clk_en_o` is 1 and `busy_o`, `resume_vld_o`, `pdf_o` and `to_o` are 0.
- R2: A `halt_i` pulse while running (clock enabled, not busy) makes `clk_en_o` 0 and `pdf_o` 1 from the next cycle. It also clears `to_o`, unless a watchdog overflow arrives in the same cycle.
- R3: `pdf_o` is cleared by a `wdt_clr_i` pulse while running and by the power-up reset. `wdt_clr_i` has no effect while halted.
- R4: `wdt_ovf_i` sets `to_o` from the next cycle, in any state.
- R5: While halted, a high-to-low transition on pin b with `wake_en_i[b]`=1 wakes the block with resume code 2'b00 (next instruction). Transitions on pins whose enable bit is 0, and rising transitions, have no effect.
- R6: While halted, a new interrupt request wakes the block. The resume code is 2'b01 (interrupt response) when a waking request has its `irq_en_i` bit set and `stack_full_i` is 0. Otherwise the code is 2'b00.
- R7: An interrupt request that was already high in the cycle the halt was accepted cannot wake the block during that halt.
- R8: While halted, `wdt_ovf_i` wakes the block with resume code 2'b10 (warm reset), and `ext_rst_i` wakes it with code 2'b11 (full initialisation).
- R9: Simultaneous wake sources are resolved in this order: external reset, then watchdog overflow, then interrupt, then pin edge.
- R10: After a wake, `busy_o` and `clk_en_o` are 1 for exactly DELAY_CYCLES cycles, starting the cycle after the wake source is seen. `resume_vld_o` is 1 only in the last of these cycles, with the resume code on `resume_act_o`. The block then runs with `busy_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-up reset, synchronous, active low |
| halt_i | input | 1 | Halt request strobe |
| wdt_clr_i | input | 1 | Watchdog-clear strobe |
| ext_rst_i | input | 1 | External reset request |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| irq_req_i | input | N_IRQ | Interrupt request flags |
| irq_en_i | input | N_IRQ | Interrupt enable bits |
| stack_full_i | input | 1 | Return stack has no free entry |
| pin_i | input | PORT_W | Wake-capable input pins |
| wake_en_i | input | PORT_W | Per-pin wake enable |
| clk_en_o | output | 1 | System clock enable |
| busy_o | output | 1 | Settling window in progress |
| resume_vld_o | output | 1 | Resume command valid (one cycle) |
| resume_act_o | output | 2 | Resume code: 00 next, 01 interrupt, 10 warm reset, 11 full init |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Time-out flag |

## Verification
The bench builds the block with four wake pins, two interrupt lines and a settling window of 16 cycles. That is small enough to cover every pin with its enable on and off, and every interrupt line against every enable and stack-full combination. It also covers all fifteen non-empty combinations of simultaneous wake sources. The short window lets the exact busy length and the position of the resume pulse be checked on every wake. The default 1024-cycle window uses the same counter logic, only wider.

// File: rtl/pwrdn_pkg.sv
// Shared types for the power-down controller.
package pwrdn_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_HALT   = 2'b01,
        ST_SETTLE = 2'b10
    } pd_state_t;

    typedef enum logic [1:0] {
        RES_NEXT = 2'b00,
        RES_IRQ  = 2'b01,
        RES_WARM = 2'b10,
        RES_FULL = 2'b11
    } resume_t;
endpackage

// File: rtl/pwrdn_wake_detect.sv
// Wake source detection and priority resolution.
// Assumes: pins idle high; clk is always on, so edges are seen while halted.
// The interrupt block mask is loaded in the cycle the halt is accepted.
module pwrdn_wake_detect
    import pwrdn_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int N_IRQ  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] wake_en_i,
    input  logic [N_IRQ-1:0]  irq_req_i,
    input  logic [N_IRQ-1:0]  irq_en_i,
    input  logic              stack_full_i,
    input  logic              wdt_ovf_i,
    input  logic              ext_rst_i,
    output logic              wake_o,
    output resume_t           act_o
);
    logic [PORT_W-1:0] pin_q;
    logic [PORT_W-1:0] fall;
    logic [N_IRQ-1:0]  irq_block_q;
    logic [N_IRQ-1:0]  irq_new;
    logic              irq_take;

    // Per-pin falling-edge detector qualified by its enable bit.
    for (genvar b = 0; b < PORT_W; b++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) pin_q[b] <= 1'b1;
            else        pin_q[b] <= pin_i[b];
        end
        assign fall[b] = pin_q[b] & ~pin_i[b] & wake_en_i[b];
    end

    // Remember requests already pending when the halt is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_block_q <= '0;
        else if (arm_i) irq_block_q <= irq_req_i;
    end

    assign irq_new  = irq_req_i & ~irq_block_q;
    assign irq_take = |(irq_new & irq_en_i) & ~stack_full_i;
    assign wake_o   = ext_rst_i | wdt_ovf_i | (|irq_new) | (|fall);

    // Fixed priority: external reset, watchdog, interrupt, pin.
    always_comb begin
        if (ext_rst_i)      act_o = RES_FULL;
        else if (wdt_ovf_i) act_o = RES_WARM;
        else if (|irq_new)  act_o = irq_take ? RES_IRQ : RES_NEXT;
        else                act_o = RES_NEXT;
    end
endmodule

// File: rtl/pwrdn_settle_timer.sv
// Settling window counter.
// Counts from zero while run_i is high; done_o marks the final cycle.
// Assumes DELAY_CYCLES >= 2.
module pwrdn_settle_timer #(
    parameter int DELAY_CYCLES = 1024,
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Window counter: cleared at wake, advances during settling.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (run_i)        cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == CNT_W'(DELAY_CYCLES - 1));
endmodule

// File: rtl/pwrdn_flags.sv
// Power-down and time-out flags.
// A halt sets the power-down flag and clears the time-out flag.
// A watchdog overflow setting the time-out flag wins over a same-cycle halt.
module pwrdn_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_acc_i,
    input  logic clr_acc_i,
    input  logic wdt_ovf_i,
    output logic pdf_o,
    output logic to_o
);
    // Power-down flag.
    always_ff @(posedge clk) begin
        if (!rst_n)          pdf_o <= 1'b0;
        else if (halt_acc_i) pdf_o <= 1'b1;
        else if (clr_acc_i)  pdf_o <= 1'b0;
    end

    // Time-out flag.
    always_ff @(posedge clk) begin
        if (!rst_n)          to_o <= 1'b0;
        else if (wdt_ovf_i)  to_o <= 1'b1;
        else if (halt_acc_i) to_o <= 1'b0;
    end
endmodule

// File: rtl/pwrdn_ctrl.sv
// Power-down and wake-up controller top.
// Sequences run -> halt -> settle -> run, gates the system clock and
// issues a resume command at the end of the settling window.
// Assumes one clk that keeps running during halt; clk_en_o gates the core.
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int PORT_W       = 8,
    parameter int N_IRQ        = 4,
    parameter int DELAY_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              wdt_clr_i,
    input  logic              ext_rst_i,
    input  logic              wdt_ovf_i,
    input  logic [N_IRQ-1:0]  irq_req_i,
    input  logic [N_IRQ-1:0]  irq_en_i,
    input  logic              stack_full_i,
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] wake_en_i,
    output logic              clk_en_o,
    output logic              busy_o,
    output logic              resume_vld_o,
    output logic [1:0]        resume_act_o,
    output logic              pdf_o,
    output logic              to_o
);
    pd_state_t state_q;
    resume_t   act_q;
    resume_t   wake_act;
    logic      wake;
    logic      halt_acc;
    logic      wake_acc;
    logic      done;

    assign halt_acc = (state_q == ST_RUN) && halt_i;
    assign wake_acc = (state_q == ST_HALT) && wake;

    pwrdn_wake_detect #(.PORT_W(PORT_W), .N_IRQ(N_IRQ)) u_wake (
        .clk(clk), .rst_n(rst_n), .arm_i(halt_acc),
        .pin_i(pin_i), .wake_en_i(wake_en_i),
        .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
        .stack_full_i(stack_full_i), .wdt_ovf_i(wdt_ovf_i),
        .ext_rst_i(ext_rst_i), .wake_o(wake), .act_o(wake_act)
    );

    pwrdn_settle_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear_i(wake_acc),
        .run_i(state_q == ST_SETTLE), .done_o(done)
    );

    pwrdn_flags u_flags (
        .clk(clk), .rst_n(rst_n), .halt_acc_i(halt_acc),
        .clr_acc_i((state_q == ST_RUN) && wdt_clr_i),
        .wdt_ovf_i(wdt_ovf_i), .pdf_o(pdf_o), .to_o(to_o)
    );

    // Mode sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:    if (halt_i) state_q <= ST_HALT;
                ST_HALT:   if (wake)   state_q <= ST_SETTLE;
                ST_SETTLE: if (done)   state_q <= ST_RUN;
                default:               state_q <= ST_RUN;
            endcase
        end
    end

    // Resume code captured at the accepted wake.
    always_ff @(posedge clk) begin
        if (!rst_n)        act_q <= RES_NEXT;
        else if (wake_acc) act_q <= wake_act;
    end

    assign clk_en_o     = (state_q != ST_HALT);
    assign busy_o       = (state_q == ST_SETTLE);
    assign resume_vld_o = done;
    assign resume_act_o = done ? act_q : RES_NEXT;
endmodule

// Property checker bound to the controller.
module pwrdn_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_i,
    input logic wdt_ovf_i,
    input logic ext_rst_i,
    input logic clk_en_o,
    input logic busy_o,
    input logic resume_vld_o,
    input logic pdf_o,
    input logic to_o
);
    // R2
    halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o && !busy_o && halt_i && !wdt_ovf_i) |=> (!clk_en_o && pdf_o && !to_o));
    // R4
    to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_i |=> to_o);
    // R8
    ext_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_o && ext_rst_i) |=> busy_o);
    // R10
    resume_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld_o |-> (busy_o && clk_en_o));
    // R10
    resume_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld_o |=> (!busy_o && clk_en_o && !resume_vld_o));
    // R10
    busy_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(!clk_en_o));
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (.*);

// File: tb/pwrdn_ctrl_test.sv
module pwrdn_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;
    localparam int NI = 2;
    localparam int DLY = 16;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 0, wclr = 0, extr = 0, wovf = 0, sfull = 0;
    logic [NI-1:0] ireq = '0, ien = '0;
    logic [PW-1:0] pins = '1, wen = '0;
    logic clk_en, busy, rvld, pdf, to;
    logic [1:0] ract;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdn_ctrl #(.PORT_W(PW), .N_IRQ(NI), .DELAY_CYCLES(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .wdt_clr_i(wclr),
        .ext_rst_i(extr), .wdt_ovf_i(wovf), .irq_req_i(ireq), .irq_en_i(ien),
        .stack_full_i(sfull), .pin_i(pins), .wake_en_i(wen),
        .clk_en_o(clk_en), .busy_o(busy), .resume_vld_o(rvld),
        .resume_act_o(ract), .pdf_o(pdf), .to_o(to)
    );

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic enter_halt();
        @(negedge clk) halt = 1;
        @(negedge clk) halt = 0;
        check("R2 clk_en after halt", clk_en, 0);
        check("R2 pdf after halt", pdf, 1);
        check("R2 to after halt", to, 0);
    endtask

    // Caller has applied the wake stimulus for one cycle; now at first busy cycle.
    task automatic settle(int exp_act, string tag);
        int vld_at = -1;
        int n_vld = 0;
        int got = -1;
        int bad = 0;
        for (int i = 0; i < DLY; i++) begin
            if (!busy || !clk_en) bad = 1;
            if (rvld) begin
                n_vld++;
                if (vld_at < 0) begin vld_at = i; got = ract; end
            end
            @(negedge clk);
        end
        check("R10 busy window", bad, 0);
        check("R10 resume position", vld_at, DLY - 1);
        check("R10 single resume", n_vld, 1);
        check("R10 busy released", busy, 0);
        check(tag, got, exp_act);
    endtask

    task automatic expect_idle(int n, string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_en || busy) bad = 1;
        end
        check(tag, bad, 0);
    endtask

    task automatic ext_wake();
        extr = 1;
        @(negedge clk) extr = 0;
        settle(3, "R8 external reset code");
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog got=hang exp=finish");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // r1_ reset state
        check("R1 clk_en", clk_en, 1);
        check("R1 busy", busy, 0);
        check("R1 resume_vld", rvld, 0);
        check("R1 pdf", pdf, 0);
        check("R1 to", to, 0);

        // R4 overflow while running, R3 clear while running
        wovf = 1;
        @(negedge clk) wovf = 0;
        check("R4 to after overflow in run", to, 1);
        enter_halt();
        ext_wake();
        check("R3 pdf kept through wake", pdf, 1);
        wclr = 1;
        @(negedge clk) wclr = 0;
        check("R3 pdf cleared by wdt clear", pdf, 0);

        // R3 wdt clear ignored while halted
        enter_halt();
        wclr = 1;
        @(negedge clk) wclr = 0;
        check("R3 pdf held while halted", pdf, 1);
        ext_wake();

        // R5 pin sweep
        for (int b = 0; b < PW; b++) begin
            for (int en = 0; en < 2; en++) begin
                wen = en ? PW'(1 << b) : ~PW'(1 << b);
                enter_halt();
                pins[b] = 1'b0;
                @(negedge clk) pins[b] = 1'b1;
                if (en) begin
                    settle(0, "R5 pin wake code");
                end else begin
                    expect_idle(4, "R5 disabled pin ignored");
                    ext_wake();
                end
            end
        end

        // R5 rising edge ignored: hold pin low across halt entry, then release
        wen = '1;
        pins[0] = 1'b0;
        enter_halt();
        pins[0] = 1'b1;
        expect_idle(4, "R5 rising edge ignored");
        ext_wake();

        // R6 interrupt sweep
        for (int i = 0; i < NI; i++) begin
            for (int en = 0; en < 2; en++) begin
                for (int sf = 0; sf < 2; sf++) begin
                    ien = en ? NI'(1 << i) : '0;
                    sfull = sf[0];
                    enter_halt();
                    ireq[i] = 1'b1;
                    @(negedge clk) ireq = '0;
                    settle((en == 1 && sf == 0) ? 1 : 0, "R6 interrupt wake code");
                end
            end
        end
        sfull = 0;

        // R7 pending request blocked, a new one still wakes
        ien = '1;
        ireq[0] = 1'b1;
        enter_halt();
        expect_idle(5, "R7 pending request ignored");
        ireq[1] = 1'b1;
        @(negedge clk) ireq = '0;
        settle(1, "R7 new request wakes");

        // R9 priority sweep: bit3 ext, bit2 wdt, bit1 irq, bit0 pin
        wen = '1;
        ien = '1;
        for (int m = 1; m < 16; m++) begin
            int exp;
            exp = m[3] ? 3 : m[2] ? 2 : m[1] ? 1 : 0;
            enter_halt();
            extr = m[3];
            wovf = m[2];
            ireq[0] = m[1];
            pins[2] = ~m[0];
            @(negedge clk);
            extr = 0; wovf = 0; ireq = '0; pins = '1;
            if (m[2]) check("R8 to set by overflow wake", to, 1);
            settle(exp, "R9 priority code");
        end

        // R8 overflow alone
        enter_halt();
        wovf = 1;
        @(negedge clk) wovf = 0;
        settle(2, "R8 overflow code");

        // R3 power-up reset clears pdf
        enter_halt();
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        check("R3 pdf cleared by reset", pdf, 0);
        check("R1 clk_en after reset", clk_en, 1);

        summary();
        $finish;
    end
endmodule